// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block collects up to 32 interrupt inputs and raises one request line towards the processor. It also reports the number of the source that should be serviced. Each source has its own trigger mode, mask bit and three-bit priority level. Level 0 is the most urgent. Among sources at the same level, the lower source number wins, in a fixed chain.

When the processor reads the acknowledge register, the controller records the level of the winning source on an in-service stack of eight entries. From then on, the request line only rises for a source whose level is strictly more urgent than the top of that stack. A handler can therefore be interrupted only by something more urgent. Writing the end-of-service register pops the stack, which restores the threshold that applied before. The inputs are expected to be synchronous to the clock already.

The register port has simple read and write strobes, a 3-bit address and 32-bit data. The address map is:

| Address | Access | Function |
|---|---|---|
| 0 | write | set mask bits |
| 0 | read | return the mask |
| 1 | write | clear mask bits |
| 2 | write | source configuration |
| 3 | read | acknowledge |
| 4 | write | end-of-service |

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source is masked and configured as high-level with priority 7. The in-service stack is empty and `irq` is low.
- R2: A write to address 0 sets the mask bits given as ones in `wdata`, and a write to address 1 clears them. A mask bit of 1 blocks its source. A read at address 0 returns the mask, bit i belonging to source i.
- R3: Trigger code 0 (low-level) requests while the input is 0, and code 1 (high-level) requests while it is 1. In both cases the request is seen in the same cycle as the input.
- R4: Trigger code 2 (falling edge) and code 3 (rising edge) latch a pending bit on the detected transition. The request is seen from the next cycle and stays after the input returns.
- R5: Among active unmasked sources, the one with the numerically lowest priority level is presented on `irq_id`.
- R6: Among active sources at the same best level, the lowest source number is presented.
- R7: A read at address 3 while `irq` is high returns bit 31 = 1 with the source number in bits 4:0. It clears the winner's edge pending bit. A level source stays active until its input is released.
- R8: An acknowledge pushes the winner's level onto the in-service stack. After that, `irq` rises only for a request whose level is strictly below the stack top.
- R9: A write to address 4 pops the in-service stack and restores the previous threshold. With an empty stack it has no effect.
- R10: A read at address 3 while `irq` is low returns 0 and leaves the stack unchanged.
- R11: A configuration write to address 2 sets the source (`wdata[4:0]`), its trigger code (`wdata[9:8]`) and its level (`wdata[14:12]`). It also clears that source's edge pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| irq_in | input | 32 | interrupt source inputs |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 3 | register address |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data, valid in the cycle of `rd_en` |
| irq | output | 1 | request to the processor |
| irq_id | output | 5 | number of the presented source |

## Verification
Directed sequences try each trigger mode on its own source. They show level modes following the input in the same cycle, and edge modes holding a latched request once the input has fallen back. Overlapping requests separate the level comparison from the chain order within a level. Nested acknowledges and end-of-service writes, including a write on an empty stack, show the threshold being held and then restored. A long random run with sparse input toggling, random reconfiguration and random acknowledge and end-of-service traffic compares every cycle against a bench model of pending bits and the stack.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam logic [ADDR_W-1:0] A_MSET = 3'd0;
  localparam logic [ADDR_W-1:0] A_MCLR = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ACK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EOS  = 3'd4;

  localparam int CFG_TYPE_LSB = 8;
  localparam int CFG_PRIO_LSB = 12;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sig,
  input  trig_e mode,
  input  logic  ack_clr,
  input  logic  cfg_clr,
  output logic  req_act
);
  logic prev_q, pend_q, pend_d, edge_hit;

  always_comb begin
    case (mode)
      TRIG_FALL: edge_hit = prev_q & ~sig;
      TRIG_RISE: edge_hit = ~prev_q & sig;
      default:   edge_hit = 1'b0;
    endcase
    pend_d = cfg_clr ? 1'b0 : ((pend_q & ~ack_clr) | edge_hit);
    case (mode)
      TRIG_LOW:  req_act = ~sig;
      TRIG_HIGH: req_act = sig;
      default:   req_act = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sig;
      pend_q <= pend_d;
    end
  end

  assert_pend_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_RISE && !prev_q && sig && !cfg_clr) |=> req_act);
  assert_pend_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_FALL && prev_q && !sig && !cfg_clr) |=> req_act);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 32,
  parameter int LVLS = 8,
  localparam int SW = $clog2(NSRC),
  localparam int LW = $clog2(LVLS)
) (
  input  logic [NSRC-1:0]         req,
  input  logic [NSRC-1:0][LW-1:0] prio,
  output logic                    any,
  output logic [LW-1:0]           best,
  output logic [SW-1:0]           win
);
  always_comb begin
    any  = |req;
    best = LW'(LVLS - 1);
    for (int l = LVLS - 1; l >= 0; l--) begin
      for (int i = 0; i < NSRC; i++) begin
        if (req[i] && prio[i] == LW'(l)) best = LW'(l);
      end
    end
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && prio[i] == best) win = SW'(i);
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int DEPTH = 8,
  parameter int LW    = 3,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] push_lvl,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] top_lvl
);
  logic [DEPTH-1:0][LW-1:0] ent_q;
  logic [PW-1:0]            sp_q, sp_d;
  logic [IW-1:0]            top_idx, wr_idx;
  logic                     do_push, do_pop;

  always_comb begin
    empty   = (sp_q == '0);
    full    = (sp_q == PW'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !push && !empty;
    top_idx = IW'(sp_q - 1'b1);
    wr_idx  = IW'(sp_q);
    top_lvl = empty ? '0 : ent_q[top_idx];
    sp_d    = sp_q;
    if (do_push)     sp_d = sp_q + 1'b1;
    else if (do_pop) sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ent_q <= '0;
    end else begin
      sp_q <= sp_d;
      if (do_push) ent_q[wr_idx] <= push_lvl;
    end
  end

  assert_push_more_urgent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !empty) |-> (push_lvl < top_lvl));
  assert_pop_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> (sp_q == $past(sp_q) - 1'b1));
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= PW'(DEPTH));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int LVLS   = 8,
  parameter int DATA_W = 32,
  localparam int SW = $clog2(NSRC),
  localparam int LW = $clog2(LVLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [SW-1:0]     irq_id
);
  logic [NSRC-1:0]         mask_q, mask_d;
  trig_e                   type_q [NSRC];
  logic [NSRC-1:0][LW-1:0] prio_q;
  logic [NSRC-1:0]         act, req, ack_clr, cfg_clr;
  logic                    cfg_we, ack_rd, eos_wr, push, any, st_empty, st_full;
  logic [SW-1:0]           cfg_src;
  logic [LW-1:0]           best, top_lvl;
  logic [LW:0]             thr;

  always_comb begin
    cfg_we  = wr_en && addr == A_CFG;
    cfg_src = wdata[SW-1:0];
    ack_rd  = rd_en && addr == A_ACK;
    eos_wr  = wr_en && addr == A_EOS;
    mask_d  = mask_q;
    if (wr_en && addr == A_MSET) mask_d = mask_q | wdata[NSRC-1:0];
    if (wr_en && addr == A_MCLR) mask_d = mask_q & ~wdata[NSRC-1:0];
    push    = ack_rd && irq;
    ack_clr = push ? (NSRC'(1) << irq_id) : '0;
    cfg_clr = cfg_we ? (NSRC'(1) << cfg_src) : '0;
    req     = act & ~mask_q;
    thr     = st_empty ? (LW + 1)'(LVLS) : {1'b0, top_lvl};
    irq     = any && ({1'b0, best} < thr);
    rdata   = '0;
    if (rd_en && addr == A_MSET) rdata[NSRC-1:0] = mask_q;
    if (ack_rd && irq) begin
      rdata[DATA_W-1] = 1'b1;
      rdata[SW-1:0]   = irq_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      prio_q <= '1;
      for (int i = 0; i < NSRC; i++) type_q[i] <= TRIG_HIGH;
    end else begin
      mask_q <= mask_d;
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_clr[i]) begin
          type_q[i] <= trig_e'(wdata[CFG_TYPE_LSB +: 2]);
          prio_q[i] <= wdata[CFG_PRIO_LSB +: LW];
        end
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .sig(irq_in[g]), .mode(type_q[g]),
      .ack_clr(ack_clr[g]), .cfg_clr(cfg_clr[g]), .req_act(act[g])
    );
  end

  irq_arbiter #(.NSRC(NSRC), .LVLS(LVLS)) u_arb (
    .req(req), .prio(prio_q), .any(any), .best(best), .win(irq_id)
  );

  irq_level_stack #(.DEPTH(LVLS), .LW(LW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(eos_wr), .push_lvl(best),
    .empty(st_empty), .full(st_full), .top_lvl(top_lvl)
  );

  assert_unmasked_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mask_q[irq_id]);
  assert_winner_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> act[irq_id]);
  assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !st_full);
  assert_below_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !st_empty) |-> (prio_q[irq_id] < top_lvl));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  logic [4:0]  irq_id;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .irq_id(irq_id)
  );

  int vectors = 0;
  int errors  = 0;

  logic [31:0] m_mask, m_prev, m_pend;
  logic [1:0]  m_type [32];
  logic [2:0]  m_prio [32];
  logic [2:0]  m_stk  [8];
  int          m_sp;

  function automatic logic m_req(input int i, input logic [31:0] inv);
    logic a;
    case (m_type[i])
      2'd0:    a = !inv[i];
      2'd1:    a = inv[i];
      default: a = m_pend[i];
    endcase
    return a && !m_mask[i];
  endfunction

  function automatic void predict(input logic [31:0] inv, output logic eirq, output logic [4:0] eid);
    int best = 8;
    int thr;
    eid = '0;
    for (int i = 0; i < 32; i++) begin
      if (m_req(i, inv) && int'(m_prio[i]) < best) begin
        best = int'(m_prio[i]);
        eid  = 5'(i);
      end
    end
    thr  = (m_sp == 0) ? 8 : int'(m_stk[m_sp-1]);
    eirq = best < thr;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // op: 0 idle, 1 write, 2 read
  task automatic step(input logic [31:0] inv, input int op, input logic [2:0] a,
                      input logic [31:0] wd, input string tag);
    logic       eirq;
    logic [4:0] eid;
    logic [31:0] erd;
    logic       ack, eos, cfg;
    @(negedge clk);
    irq_in = inv; wr_en = (op == 1); rd_en = (op == 2); addr = a; wdata = wd;
    #1;
    predict(inv, eirq, eid);
    chk(tag, "irq", {31'b0, irq}, {31'b0, eirq});
    if (eirq) chk(tag, "irq_id", {27'b0, irq_id}, {27'b0, eid});
    if (op == 2) begin
      erd = '0;
      if (a == 3'd0) erd = m_mask;
      if (a == 3'd3 && eirq) erd = {1'b1, 26'b0, eid};
      chk(tag, "rdata", rdata, erd);
    end
    ack = (op == 2) && (a == 3'd3) && eirq;
    eos = (op == 1) && (a == 3'd4);
    cfg = (op == 1) && (a == 3'd2);
    for (int i = 0; i < 32; i++) begin
      logic p, ed;
      ed = (m_type[i] == 2'd2) ? (m_prev[i] & ~inv[i]) :
           (m_type[i] == 2'd3) ? (~m_prev[i] & inv[i]) : 1'b0;
      p = m_pend[i];
      if (ack && int'(eid) == i) p = 1'b0;
      p = p | ed;
      if (cfg && int'(wd[4:0]) == i) p = 1'b0;
      m_pend[i] = p;
    end
    if (ack && m_sp < 8) begin m_stk[m_sp] = m_prio[eid]; m_sp++; end
    if (eos && m_sp > 0) m_sp--;
    if (op == 1 && a == 3'd0) m_mask = m_mask | wd;
    if (op == 1 && a == 3'd1) m_mask = m_mask & ~wd;
    if (cfg) begin m_type[wd[4:0]] = wd[9:8]; m_prio[wd[4:0]] = wd[14:12]; end
    m_prev = inv;
  endtask

  function automatic logic [31:0] cfgw(input int src, input int typ, input int lvl);
    return (32'(lvl) << 12) | (32'(typ) << 8) | 32'(src);
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] inv;
    void'($urandom(32'd1234));
    rst_n = 1'b0; irq_in = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    m_mask = '1; m_prev = '0; m_pend = '0; m_sp = 0;
    for (int i = 0; i < 32; i++) begin m_type[i] = 2'd1; m_prio[i] = 3'd7; end
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step(32'hFFFF_FFFF, 2, 3'd0, 0, "R1");
    step(32'h0, 0, 3'd0, 0, "R1");
    // R2: mask set / clear / read
    step(32'h0, 1, 3'd1, 32'h0000_00F0, "R2");
    step(32'h0, 2, 3'd0, 0, "R2");
    step(32'h0, 1, 3'd0, 32'h0000_0010, "R2");
    step(32'h0, 2, 3'd0, 0, "R2");
    step(32'h0000_0010, 0, 3'd0, 0, "R2");
    // R3: level modes
    step(32'h0, 1, 3'd2, cfgw(6, 0, 3), "R3");
    step(32'h0, 0, 3'd0, 0, "R3");
    step(32'h40, 0, 3'd0, 0, "R3");
    step(32'h60, 0, 3'd0, 0, "R3");
    // R5: urgency
    step(32'h20, 0, 3'd0, 0, "R5");
    step(32'h20, 1, 3'd2, cfgw(5, 1, 1), "R5");
    step(32'h20, 0, 3'd0, 0, "R5");
    // R6: chain within a level
    step(32'h20, 1, 3'd2, cfgw(5, 1, 3), "R6");
    step(32'h20, 0, 3'd0, 0, "R6");
    step(32'h40, 1, 3'd2, cfgw(5, 1, 7), "R6");
    // R4: edge modes
    step(32'h40, 1, 3'd2, cfgw(7, 3, 0), "R4");
    step(32'hC0, 0, 3'd0, 0, "R4");
    step(32'hC0, 0, 3'd0, 0, "R4");
    step(32'h40, 0, 3'd0, 0, "R4");
    // R7 / R8: acknowledge edge source, then level source
    step(32'h40, 2, 3'd3, 0, "R7");
    step(32'h40, 0, 3'd0, 0, "R7");
    step(32'h40, 1, 3'd4, 0, "R9");
    step(32'h00, 0, 3'd0, 0, "R8");
    step(32'h00, 2, 3'd3, 0, "R8");
    step(32'h00, 0, 3'd0, 0, "R8");
    step(32'h80, 0, 3'd0, 0, "R8");
    step(32'h80, 0, 3'd0, 0, "R8");
    step(32'h80, 2, 3'd3, 0, "R8");
    step(32'h00, 0, 3'd0, 0, "R8");
    // R9: pops restore thresholds, empty pop ignored
    step(32'h00, 1, 3'd4, 0, "R9");
    step(32'h00, 0, 3'd0, 0, "R9");
    step(32'h00, 1, 3'd4, 0, "R9");
    step(32'h00, 0, 3'd0, 0, "R9");
    step(32'h00, 1, 3'd4, 0, "R9");
    step(32'h00, 0, 3'd0, 0, "R9");
    // R10: acknowledge without request
    step(32'h40, 1, 3'd0, 32'h40, "R10");
    step(32'h40, 2, 3'd3, 0, "R10");
    step(32'h40, 1, 3'd1, 32'h40, "R10");
    step(32'h00, 0, 3'd0, 0, "R10");
    // R11: reconfiguration drops a pending edge
    step(32'h40, 1, 3'd0, 32'h80, "R11");
    step(32'hC0, 0, 3'd0, 0, "R11");
    step(32'hC0, 1, 3'd2, cfgw(7, 3, 0), "R11");
    step(32'h40, 1, 3'd1, 32'h80, "R11");
    step(32'h40, 0, 3'd0, 0, "R11");
    // random phase, checked against the bench model (R5, R6, R8)
    for (int i = 0; i < 32; i++) step(32'h40, 1, 3'd2, cfgw(i, $urandom % 4, $urandom % 8), "R11");
    step(32'h40, 1, 3'd1, 32'hFFFF_FFFF, "R2");
    inv = $urandom;
    for (int n = 0; n < 4000; n++) begin
      int r;
      inv = inv ^ ($urandom & $urandom & $urandom);
      r = $urandom % 100;
      if (r < 12)      step(inv, 2, 3'd3, 0, "R8");
      else if (r < 21) step(inv, 1, 3'd4, 0, "R9");
      else if (r < 24) step(inv, 1, 3'd2, cfgw($urandom % 32, $urandom % 4, $urandom % 8), "R11");
      else if (r < 26) step(inv, 1, 3'd0, 32'h1 << ($urandom % 32), "R2");
      else if (r < 28) step(inv, 1, 3'd1, 32'h1 << ($urandom % 32), "R2");
      else if (r < 30) step(inv, 2, 3'd0, 0, "R2");
      else             step(inv, 0, 3'd0, 0, "R6");
    end
    step(inv, 0, 3'd0, 0, "R5");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule